// File: doc/BRIEF.md
# Banked UART register access unit

This block is the host-facing register file of a UART-style peripheral. A host reaches it through a simple synchronous port with an address, write enable, write data, read enable and registered read data. Registers sit on 32-bit boundaries, 4 bytes apart. Which register a given offset reaches depends on the value currently held in the line control register (LCR). This value selects one of three banks: operational, divisor-latch or enhanced. Configuration registers live inside the block. Status bytes (interrupt identification, line status, modem status) and the receive data byte arrive on input ports. Receive reads and transmit writes leave the block as single-cycle strobes for external FIFOs.

Some configuration fields are write-protected. They accept new data only while the enhanced-function enable bit, bit 4 of the enhanced feature register (EFR), is set. While EFR[4] and the modem control bit MCR[6] are both set, two offsets are redirected to a transmission control register and a trigger level register.

Top module: `uart_regbank`

## Requirements
- R1: The bank is operational when LCR[7]=0, divisor when LCR[7]=1 and LCR≠0xBF, and enhanced when LCR=0xBF. LCR is read and written at offset 0x0C in every bank.
- R2: At offset 0x00, the operational bank turns a read into a one-cycle `rx_pop` strobe that returns `rx_data`, and a write into a one-cycle `tx_push` strobe with `tx_data`=`wr_data`. The other two banks read and write the divisor low byte there, with no strobe.
- R3: Offset 0x04 reaches the interrupt enable register (IER) in the operational bank and the divisor high byte in the other two banks.
- R4: Offset 0x08 reads `iir_in` and writes the FIFO control byte (`fcr_o`) in the operational and divisor banks. In the enhanced bank it reads and writes EFR.
- R5: In the operational and divisor banks, offset 0x10 reaches MCR and offset 0x14 reads `lsr_in`; a write to 0x14 changes no register. In the enhanced bank these offsets reach XON1 and XON2.
- R6: Offset 0x18 reads `msr_in` (writes ignored) and offset 0x1C reaches the scratch byte, in the non-enhanced banks. In the enhanced bank they reach XOFF1 and XOFF2. When EFR[4]=1 and MCR[6]=1, in any bank, they reach the transmission control and trigger level registers instead.
- R7: A write to IER always updates IER[3:0]. It updates IER[7:4] only when EFR[4]=1; otherwise those bits keep their value.
- R8: Writes update MCR[7:5] and FCR[5:4] only when EFR[4]=1. The other bits of both registers are always written.
- R9: An LCR write changes the decoding of the access in the very next cycle.
- R10: An offset that is not a multiple of 4, or is above 0x1C, reads as 0x00, and a write to it changes no register.
- R11: Synchronous active-high reset clears every stored register (LCR, IER, FCR, MCR, EFR, divisor bytes, scratch, XON/XOFF, TCR, TLR) to 0x00.
- R12: `rd_data` is registered. It shows the addressed value in the cycle after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| rx_data | input | 8 | Head byte of the receive FIFO |
| iir_in | input | 8 | Interrupt identification status |
| lsr_in | input | 8 | Line status |
| msr_in | input | 8 | Modem status |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_data | output | 8 | Byte for the transmit FIFO |
| lcr_o | output | 8 | Line control register value |
| ier_o | output | 8 | Interrupt enable register value |
| fcr_o | output | 8 | FIFO control register value |
| mcr_o | output | 8 | Modem control register value |
| efr_o | output | 8 | Enhanced feature register value |
| dll_o | output | 8 | Divisor low byte |
| dlh_o | output | 8 | Divisor high byte |

## Verification
The bench switches LCR between all three banks. It writes to offset 0x00 in the cycle right after an LCR change, so a design that delayed the bank decode would push a byte to the transmit FIFO instead of loading the divisor. It writes the protected IER, MCR and FCR fields with EFR[4] both clear and set. A design that ignored the lock would show the new high bits, and one that over-applied it would drop the low bits. It also sets MCR[6] with and without EFR[4] and checks that offsets 0x18/0x1C are redirected only when both are set. It writes to read-only and unmapped offsets and then reads back the registers those writes could have reached.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int DATA_W       = 8;
    localparam int LOCK_BIT     = 4;      // EFR bit enabling protected fields
    localparam int TC_SEL_BIT   = 6;      // MCR bit enabling TCR/TLR redirect
    localparam int BANK_BIT     = 7;      // LCR bit selecting divisor bank
    localparam logic [DATA_W-1:0] ENH_KEY = 8'hBF;

    localparam logic [DATA_W-1:0] IER_LOCK_MASK = 8'hF0;
    localparam logic [DATA_W-1:0] MCR_LOCK_MASK = 8'hE0;
    localparam logic [DATA_W-1:0] FCR_LOCK_MASK = 8'h30;

    typedef enum logic [1:0] {
        BANK_OPER,
        BANK_DIV,
        BANK_ENH
    } bank_e;

    typedef enum logic [4:0] {
        T_NONE,
        T_HOLD,
        T_IER,
        T_DLL,
        T_DLH,
        T_IIR_FCR,
        T_EFR,
        T_LCR,
        T_MCR,
        T_LSR,
        T_MSR,
        T_SPR,
        T_XON1,
        T_XON2,
        T_XOFF1,
        T_XOFF2,
        T_TCR,
        T_TLR
    } tgt_e;

    typedef struct packed {
        logic [DATA_W-1:0] lcr;
        logic [DATA_W-1:0] ier;
        logic [DATA_W-1:0] fcr;
        logic [DATA_W-1:0] mcr;
        logic [DATA_W-1:0] efr;
        logic [DATA_W-1:0] dll;
        logic [DATA_W-1:0] dlh;
        logic [DATA_W-1:0] spr;
        logic [DATA_W-1:0] xon1;
        logic [DATA_W-1:0] xon2;
        logic [DATA_W-1:0] xoff1;
        logic [DATA_W-1:0] xoff2;
        logic [DATA_W-1:0] tcr;
        logic [DATA_W-1:0] tlr;
    } cfg_t;

    function automatic bank_e bank_of(input logic [DATA_W-1:0] lcr);
        if (!lcr[BANK_BIT])     return BANK_OPER;
        else if (lcr == ENH_KEY) return BANK_ENH;
        else                     return BANK_DIV;
    endfunction

    // Bits set in mask take the old value when locked.
    function automatic logic [DATA_W-1:0] guard_bits(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [DATA_W-1:0] mask,
        input logic              unlocked
    );
        if (unlocked) return new_v;
        return (new_v & ~mask) | (old_v & mask);
    endfunction

endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] lcr,
    input  logic              tc_en,
    output bank_e             bank,
    output tgt_e              tgt
);
    localparam int IDX_W   = ADDR_W - 2;
    localparam int N_SLOTS = 8;

    logic [IDX_W-1:0] idx;
    logic             mapped;
    logic             enh;
    logic             oper;

    assign idx    = addr[ADDR_W-1:2];
    assign mapped = (addr[1:0] == 2'b00) && (idx < IDX_W'(N_SLOTS));
    assign bank   = bank_of(lcr);
    assign enh    = (bank == BANK_ENH);
    assign oper   = (bank == BANK_OPER);

    always_comb begin
        tgt = T_NONE;
        if (mapped) begin
            unique case (idx[2:0])
                3'd0: tgt = oper ? T_HOLD : T_DLL;
                3'd1: tgt = oper ? T_IER  : T_DLH;
                3'd2: tgt = enh  ? T_EFR  : T_IIR_FCR;
                3'd3: tgt = T_LCR;
                3'd4: tgt = enh  ? T_XON1 : T_MCR;
                3'd5: tgt = enh  ? T_XON2 : T_LSR;
                3'd6: tgt = tc_en ? T_TCR : (enh ? T_XOFF1 : T_MSR);
                3'd7: tgt = tc_en ? T_TLR : (enh ? T_XOFF2 : T_SPR);
                default: tgt = T_NONE;
            endcase
        end
    end

endmodule

// File: rtl/uart_regbank_store.sv
module uart_regbank_store
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg
);
    logic unlocked;
    assign unlocked = cfg.efr[LOCK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (tgt)
                T_LCR:     cfg.lcr   <= wr_data;
                T_IER:     cfg.ier   <= guard_bits(cfg.ier, wr_data, IER_LOCK_MASK, unlocked);
                T_IIR_FCR: cfg.fcr   <= guard_bits(cfg.fcr, wr_data, FCR_LOCK_MASK, unlocked);
                T_MCR:     cfg.mcr   <= guard_bits(cfg.mcr, wr_data, MCR_LOCK_MASK, unlocked);
                T_EFR:     cfg.efr   <= wr_data;
                T_DLL:     cfg.dll   <= wr_data;
                T_DLH:     cfg.dlh   <= wr_data;
                T_SPR:     cfg.spr   <= wr_data;
                T_XON1:    cfg.xon1  <= wr_data;
                T_XON2:    cfg.xon2  <= wr_data;
                T_XOFF1:   cfg.xoff1 <= wr_data;
                T_XOFF2:   cfg.xoff2 <= wr_data;
                T_TCR:     cfg.tcr   <= wr_data;
                T_TLR:     cfg.tlr   <= wr_data;
                default:   ;
            endcase
        end
    end

    assert_ier_lock_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tgt == T_IER && !cfg.efr[LOCK_BIT])
        |=> (cfg.ier[7:4] == $past(cfg.ier[7:4])) && (cfg.ier[3:0] == $past(wr_data[3:0])));

    assert_mcr_lock_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tgt == T_MCR && !cfg.efr[LOCK_BIT])
        |=> cfg.mcr[7:5] == $past(cfg.mcr[7:5]));

    assert_fcr_lock_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tgt == T_IIR_FCR && !cfg.efr[LOCK_BIT])
        |=> cfg.fcr[5:4] == $past(cfg.fcr[5:4]));

    assert_ro_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (tgt == T_LSR || tgt == T_MSR || tgt == T_NONE))
        |=> cfg == $past(cfg));

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    input  logic [7:0]        rx_data,
    input  logic [7:0]        iir_in,
    input  logic [7:0]        lsr_in,
    input  logic [7:0]        msr_in,
    output logic              rx_pop,
    output logic              tx_push,
    output logic [7:0]        tx_data,
    output logic [7:0]        lcr_o,
    output logic [7:0]        ier_o,
    output logic [7:0]        fcr_o,
    output logic [7:0]        mcr_o,
    output logic [7:0]        efr_o,
    output logic [7:0]        dll_o,
    output logic [7:0]        dlh_o
);
    cfg_t              cfg;
    bank_e             bank;
    tgt_e              tgt;
    logic              tc_en;
    logic [DATA_W-1:0] rd_mux;

    assign tc_en = cfg.efr[LOCK_BIT] && cfg.mcr[TC_SEL_BIT];

    uart_regbank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (addr),
        .lcr   (cfg.lcr),
        .tc_en (tc_en),
        .bank  (bank),
        .tgt   (tgt)
    );

    uart_regbank_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .tgt     (tgt),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    always_comb begin
        unique case (tgt)
            T_HOLD:    rd_mux = rx_data;
            T_IER:     rd_mux = cfg.ier;
            T_DLL:     rd_mux = cfg.dll;
            T_DLH:     rd_mux = cfg.dlh;
            T_IIR_FCR: rd_mux = iir_in;
            T_EFR:     rd_mux = cfg.efr;
            T_LCR:     rd_mux = cfg.lcr;
            T_MCR:     rd_mux = cfg.mcr;
            T_LSR:     rd_mux = lsr_in;
            T_MSR:     rd_mux = msr_in;
            T_SPR:     rd_mux = cfg.spr;
            T_XON1:    rd_mux = cfg.xon1;
            T_XON2:    rd_mux = cfg.xon2;
            T_XOFF1:   rd_mux = cfg.xoff1;
            T_XOFF2:   rd_mux = cfg.xoff2;
            T_TCR:     rd_mux = cfg.tcr;
            T_TLR:     rd_mux = cfg.tlr;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign rx_pop  = rd_en && (tgt == T_HOLD);
    assign tx_push = wr_en && (tgt == T_HOLD);
    assign tx_data = wr_data;

    assign lcr_o = cfg.lcr;
    assign ier_o = cfg.ier;
    assign fcr_o = cfg.fcr;
    assign mcr_o = cfg.mcr;
    assign efr_o = cfg.efr;
    assign dll_o = cfg.dll;
    assign dlh_o = cfg.dlh;

    assert_fifo_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_pop || tx_push) |-> (bank == BANK_OPER && !lcr_o[BANK_BIT]));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && tgt == T_NONE) |=> rd_data == '0);

    assert_lcr_next_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tgt == T_LCR) |=> lcr_o == $past(wr_data));

    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !$past(rst)) |=> $stable(rd_data));

endmodule

// File: tb/uart_regbank_test.sv
module uart_regbank_test;

    typedef struct packed {
        logic       wr;
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] e;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 60;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h0C, 8'h00, 8'h00, 4'd11}, // R11 LCR reset
        '{1'b0, 8'h04, 8'h00, 8'h00, 4'd11}, // R11 IER reset
        '{1'b1, 8'h04, 8'hFF, 8'h00, 4'd7 },
        '{1'b0, 8'h04, 8'h00, 8'h0F, 4'd7 }, // R7 locked high nibble
        '{1'b0, 8'h08, 8'h00, 8'hC1, 4'd4 }, // R4 IIR
        '{1'b0, 8'h14, 8'h00, 8'h60, 4'd5 }, // R5 LSR
        '{1'b0, 8'h18, 8'h00, 8'h3B, 4'd6 }, // R6 MSR
        '{1'b1, 8'h1C, 8'h5A, 8'h00, 4'd6 },
        '{1'b0, 8'h1C, 8'h00, 8'h5A, 4'd6 }, // R6 scratch
        '{1'b1, 8'h10, 8'hFF, 8'h00, 4'd8 },
        '{1'b0, 8'h10, 8'h00, 8'h1F, 4'd8 }, // R8 MCR locked
        '{1'b1, 8'h0C, 8'h83, 8'h00, 4'd1 },
        '{1'b0, 8'h0C, 8'h00, 8'h83, 4'd1 }, // R1 divisor bank
        '{1'b1, 8'h00, 8'h34, 8'h00, 4'd2 },
        '{1'b1, 8'h04, 8'h12, 8'h00, 4'd3 },
        '{1'b0, 8'h00, 8'h00, 8'h34, 4'd2 }, // R2 DLL
        '{1'b0, 8'h04, 8'h00, 8'h12, 4'd3 }, // R3 DLH
        '{1'b0, 8'h08, 8'h00, 8'hC1, 4'd4 }, // R4 IIR in divisor bank
        '{1'b0, 8'h10, 8'h00, 8'h1F, 4'd5 }, // R5 MCR in divisor bank
        '{1'b0, 8'h1C, 8'h00, 8'h5A, 4'd6 }, // R6 scratch in divisor bank
        '{1'b1, 8'h0C, 8'hBF, 8'h00, 4'd1 },
        '{1'b0, 8'h00, 8'h00, 8'h34, 4'd2 }, // R2 DLL in enhanced
        '{1'b0, 8'h04, 8'h00, 8'h12, 4'd3 }, // R3 DLH in enhanced
        '{1'b0, 8'h08, 8'h00, 8'h00, 4'd4 }, // R4 EFR reset
        '{1'b1, 8'h08, 8'h10, 8'h00, 4'd4 },
        '{1'b1, 8'h10, 8'h11, 8'h00, 4'd5 },
        '{1'b1, 8'h14, 8'h22, 8'h00, 4'd5 },
        '{1'b1, 8'h18, 8'h33, 8'h00, 4'd6 },
        '{1'b1, 8'h1C, 8'h44, 8'h00, 4'd6 },
        '{1'b0, 8'h10, 8'h00, 8'h11, 4'd5 }, // R5 XON1
        '{1'b0, 8'h14, 8'h00, 8'h22, 4'd5 }, // R5 XON2
        '{1'b0, 8'h18, 8'h00, 8'h33, 4'd6 }, // R6 XOFF1
        '{1'b0, 8'h1C, 8'h00, 8'h44, 4'd6 }, // R6 XOFF2
        '{1'b1, 8'h0C, 8'h03, 8'h00, 4'd1 },
        '{1'b0, 8'h0C, 8'h00, 8'h03, 4'd1 }, // R1 operational
        '{1'b1, 8'h04, 8'hF5, 8'h00, 4'd7 },
        '{1'b0, 8'h04, 8'h00, 8'hF5, 4'd7 }, // R7 unlocked IER
        '{1'b1, 8'h10, 8'hE0, 8'h00, 4'd8 },
        '{1'b0, 8'h10, 8'h00, 8'hE0, 4'd8 }, // R8 unlocked MCR
        '{1'b1, 8'h18, 8'h66, 8'h00, 4'd6 },
        '{1'b1, 8'h1C, 8'h77, 8'h00, 4'd6 },
        '{1'b0, 8'h18, 8'h00, 8'h66, 4'd6 }, // R6 TCR
        '{1'b0, 8'h1C, 8'h00, 8'h77, 4'd6 }, // R6 TLR
        '{1'b1, 8'h10, 8'h00, 8'h00, 4'd6 },
        '{1'b0, 8'h18, 8'h00, 8'h3B, 4'd6 }, // R6 MSR back
        '{1'b0, 8'h1C, 8'h00, 8'h5A, 4'd6 }, // R6 scratch kept
        '{1'b0, 8'h20, 8'h00, 8'h00, 4'd10}, // R10 above range
        '{1'b1, 8'h20, 8'hFF, 8'h00, 4'd10},
        '{1'b0, 8'h02, 8'h00, 8'h00, 4'd10}, // R10 unaligned
        '{1'b0, 8'h0C, 8'h00, 8'h03, 4'd10}, // R10 LCR untouched
        '{1'b1, 8'h10, 8'h40, 8'h00, 4'd6 },
        '{1'b1, 8'h0C, 8'hBF, 8'h00, 4'd1 },
        '{1'b0, 8'h18, 8'h00, 8'h66, 4'd6 }, // R6 TCR in enhanced
        '{1'b0, 8'h10, 8'h00, 8'h11, 4'd5 }, // R5 XON1 kept
        '{1'b1, 8'h0C, 8'h00, 8'h00, 4'd1 },
        '{1'b1, 8'h14, 8'hFF, 8'h00, 4'd5 },
        '{1'b1, 8'h0C, 8'hBF, 8'h00, 4'd1 },
        '{1'b0, 8'h14, 8'h00, 8'h22, 4'd5 }, // R5 LSR write ignored
        '{1'b0, 8'h1C, 8'h00, 8'h77, 4'd6 }, // R6 TLR
        '{1'b1, 8'h0C, 8'h00, 8'h00, 4'd1 }
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] rx_data = 8'hA5;
    logic [7:0] iir_in  = 8'hC1;
    logic [7:0] lsr_in  = 8'h60;
    logic [7:0] msr_in  = 8'h3B;
    logic       rx_pop, tx_push;
    logic [7:0] tx_data, lcr_o, ier_o, fcr_o, mcr_o, efr_o, dll_o, dlh_o;

    logic       s_pop, s_push;
    logic [7:0] s_txd;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    uart_regbank uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_data(rx_data), .iir_in(iir_in),
        .lsr_in(lsr_in), .msr_in(msr_in), .rx_pop(rx_pop), .tx_push(tx_push),
        .tx_data(tx_data), .lcr_o(lcr_o), .ier_o(ier_o), .fcr_o(fcr_o),
        .mcr_o(mcr_o), .efr_o(efr_o), .dll_o(dll_o), .dlh_o(dlh_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One access; inputs change 1 ns after an edge, strobes sampled before the next.
    task automatic access(input logic w, input logic [7:0] a, input logic [7:0] d);
        addr = a; wr_en = w; rd_en = !w; wr_data = d;
        #1;
        s_pop = rx_pop; s_push = tx_push; s_txd = tx_data;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R11 outputs after reset
        check("R11", lcr_o, 8'h00); check("R11", ier_o, 8'h00);
        check("R11", mcr_o, 8'h00); check("R11", efr_o, 8'h00);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].a, VEC[i].d);
            if (!VEC[i].wr) check($sformatf("R%0d vec %0d", VEC[i].req, i), rd_data, VEC[i].e);
        end

        // R9: divisor write in the cycle right after the LCR change
        access(1'b1, 8'h0C, 8'h80);
        access(1'b1, 8'h00, 8'h99);
        check("R9 no push", {7'd0, s_push}, 8'h00);
        access(1'b0, 8'h00, 8'h00);
        check("R9 DLL", rd_data, 8'h99);
        check("R9 dll_o", dll_o, 8'h99);
        // R2: transmit and receive strobes in operational bank
        access(1'b1, 8'h0C, 8'h00);
        access(1'b1, 8'h00, 8'h5C);
        check("R2 push", {7'd0, s_push}, 8'h01);
        check("R2 txdata", s_txd, 8'h5C);
        access(1'b0, 8'h00, 8'h00);
        check("R2 pop", {7'd0, s_pop}, 8'h01);
        check("R2 rhr", rd_data, 8'hA5);
        // R12: read data holds while idle
        @(posedge clk); #1;
        check("R12 hold", rd_data, 8'hA5);

        // R8: FCR with lock open, then closed
        access(1'b1, 8'h08, 8'hFF);
        check("R8 fcr open", fcr_o, 8'hFF);
        access(1'b1, 8'h0C, 8'hBF);
        access(1'b1, 8'h08, 8'h00);
        access(1'b1, 8'h0C, 8'h00);
        access(1'b1, 8'h08, 8'h00);
        check("R8 fcr locked", fcr_o, 8'h30);
        // R7: IER high nibble locked
        access(1'b1, 8'h04, 8'h0A);
        access(1'b0, 8'h04, 8'h00);
        check("R7 ier locked", rd_data, 8'hFA);
        // R8: MCR high bits locked (MCR was 40)
        access(1'b1, 8'h10, 8'hFF);
        access(1'b0, 8'h10, 8'h00);
        check("R8 mcr locked", rd_data, 8'h5F);
        // R6: MCR[6]=1 without EFR[4] gives no redirect
        access(1'b0, 8'h18, 8'h00);
        check("R6 no redirect", rd_data, 8'h3B);

        // R11: reset in mid-run
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        check("R11 lcr", lcr_o, 8'h00); check("R11 fcr", fcr_o, 8'h00);
        check("R11 dll", dll_o, 8'h00); check("R11 dlh", dlh_o, 8'h00);
        check("R11 ier", ier_o, 8'h00); check("R11 mcr", mcr_o, 8'h00);
        access(1'b0, 8'h1C, 8'h00);
        check("R11 spr", rd_data, 8'h00);
        access(1'b1, 8'h0C, 8'hBF);
        access(1'b0, 8'h18, 8'h00);
        check("R11 xoff1", rd_data, 8'h00);
        access(1'b1, 8'h0C, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule